// File: doc/BRIEF.md
# Output Virtual Channel Status Tracker

This block keeps the state of every output virtual channel of every output port of a router. Each channel has an ownership bit and a count of the free slots left in the downstream buffer. From that state the block offers, for each port, one candidate channel that a new packet may claim. It also keeps a registered flag per port that tells the input side whether a packet with no channel yet may request that port in the next cycle.

Channels are given out only when the switch allocator grants a head flit. The input port then names the port's current candidate, and that channel becomes owned. When a tail flit is granted, the channel is handed back. Every granted flit uses up one credit, and every credit-return pulse from downstream gives one back. A channel can be claimed again as soon as its tail has left and at least one slot is free downstream, even while older flits still sit there. Candidates rotate round-robin among the free channels of a port. The per-port flag looks ahead: it drops when the last well-stocked free channel is being claimed in the current cycle.

Top module: `ovc_status_tracker`

## Requirements
- R1: After reset every channel is unowned and holds DEPTH credits. Every `cand_vld` bit and every `port_avail` bit is 1, every `cand_vc` field is 0, and every `vc_full` and `vc_nfull` bit is 0.
- R2: A channel is free when it is unowned and has at least one credit. `cand_vld[p]` is 1 exactly when port p has a free channel, and then `cand_vc[p*VW +: VW]` names one of them. Channel v of port p sits at flat index p*NVC+v in every per-channel vector.
- R3: The candidate search starts one past the channel most recently claimed on that port, and wraps at NVC.
- R4: A granted head flit makes the named channel owned. A granted tail flit makes it unowned. A granted flit that is both head and tail leaves the channel unowned. Each change is visible one clock after the grant.
- R5: Every granted flit removes one credit from its channel. `vc_full` is 1 at zero credits and `vc_nfull` is 1 at exactly one credit.
- R6: A `cred_ret` pulse adds one credit. A pulse in the same cycle as a grant on that channel leaves the count unchanged.
- R7: `port_avail[p]` is registered. It is loaded with 0 when port p has no free channel holding more than one credit. It is also loaded with 0 when there is exactly one such channel and it is claimed in that cycle. Otherwise it is loaded with 1.
- R8: A channel released by a tail flit becomes a candidate again once it has one credit, without waiting for DEPTH credits.
- R9: Grants from different input ports in the same cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gnt_vld | input | NIN | Switch grant valid, one per input port |
| gnt_port | input | NIN*PW | Granted output port, per input port |
| gnt_vc | input | NIN*VW | Channel used by the granted flit, per input port |
| gnt_head | input | NIN | Granted flit is a head flit |
| gnt_tail | input | NIN | Granted flit is a tail flit |
| cred_ret | input | NPORT*NVC | Credit-return pulse per channel |
| cand_vc | output | NPORT*VW | Candidate channel index per port |
| cand_vld | output | NPORT | Port has a free channel |
| port_avail | output | NPORT | Registered: new packet may request the port |
| vc_full | output | NPORT*NVC | Channel has zero credits |
| vc_nfull | output | NPORT*NVC | Channel has exactly one credit |

## Verification
Ownership, credit counts and the rotation pointer change on the clock edge that takes a grant or credit pulse. Candidate, full and nearly-full outputs are decoded from that state, so they are due one edge after the stimulus. The availability flag is itself a register loaded from the state before that edge, so it can trail a change in the channels by one more edge. The bench checks this case on purpose: it samples the flag both after the releasing edge and after a following idle edge. Stimulus is applied on falling edges, and every output is sampled on the falling edge after the edge in question.

// File: rtl/ovc_pkg.sv
// Shared helpers for the output channel status tracker.
// Assumes channel v of port p is stored at flat index p*nvc+v.
package ovc_pkg;

    // Flat channel index from port and channel number.
    function automatic int ovc_flat(input int port, input int vc, input int nvc);
        return port * nvc + vc;
    endfunction

    // Width of an index field, at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ovc_grant_decode.sv
// Turns per-input-port switch grants into per-channel strobes.
// Assumes the switch allocator grants each output port to at most one input.
module ovc_grant_decode #(
    parameter int NIN   = 4,
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    localparam int PW   = ovc_pkg::idx_width(NPORT),
    localparam int VW   = ovc_pkg::idx_width(NVC),
    localparam int NCH  = NPORT * NVC
) (
    input  logic [NIN-1:0]    gnt_vld,
    input  logic [NIN*PW-1:0] gnt_port,
    input  logic [NIN*VW-1:0] gnt_vc,
    input  logic [NIN-1:0]    gnt_head,
    input  logic [NIN-1:0]    gnt_tail,
    output logic [NCH-1:0]    use_stb,
    output logic [NCH-1:0]    asg_stb,
    output logic [NCH-1:0]    rel_stb
);
    logic [NIN-1:0][NCH-1:0] hit;

    for (genvar i = 0; i < NIN; i++) begin : g_in
        // One-hot decode of the channel this input's grant touches.
        always_comb begin
            hit[i] = '0;
            for (int c = 0; c < NCH; c++) begin
                if (gnt_vld[i] &&
                    c == ovc_pkg::ovc_flat(int'(gnt_port[i*PW +: PW]),
                                           int'(gnt_vc[i*VW +: VW]), NVC))
                    hit[i][c] = 1'b1;
            end
        end
    end

    // Merge all inputs, gating by head and tail flags.
    always_comb begin
        use_stb = '0;
        asg_stb = '0;
        rel_stb = '0;
        for (int i = 0; i < NIN; i++) begin
            use_stb = use_stb | hit[i];
            asg_stb = asg_stb | (hit[i] & {NCH{gnt_head[i]}});
            rel_stb = rel_stb | (hit[i] & {NCH{gnt_tail[i]}});
        end
    end
endmodule

// File: rtl/ovc_channel_state.sv
// State of one output channel: ownership bit and downstream credit count.
// Assumes credit returns never push the count past DEPTH.
module ovc_channel_state #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_stb,
    input  logic          asg_stb,
    input  logic          rel_stb,
    input  logic          cred_ret,
    output logic          owned,
    output logic [CW-1:0] credits,
    output logic          free,
    output logic          rich,
    output logic          full,
    output logic          nfull
);
    // Ownership: release wins so a head+tail flit leaves the channel unowned.
    always_ff @(posedge clk) begin
        if (!rst_n)       owned <= 1'b0;
        else if (rel_stb) owned <= 1'b0;
        else if (asg_stb) owned <= 1'b1;
    end

    // Credit counter: a return and a use in the same cycle cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)                    credits <= CW'(DEPTH);
        else if (cred_ret && !use_stb) credits <= credits + CW'(1);
        else if (use_stb && !cred_ret) credits <= credits - CW'(1);
    end

    // Status decodes of the stored state.
    always_comb begin
        full  = (credits == '0);
        nfull = (credits == CW'(1));
        free  = !owned && !full;
        rich  = free && (credits > CW'(1));
    end
endmodule

// File: rtl/ovc_port_pick.sv
// Per output port: round-robin candidate among free channels and the
// registered, look-ahead availability flag for new packets.
// Assumes at most one channel of the port is claimed per cycle.
module ovc_port_pick #(
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    localparam int VW   = ovc_pkg::idx_width(NVC),
    localparam logic AV_RST = (DEPTH > 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NVC-1:0] free,
    input  logic [NVC-1:0] rich,
    input  logic [NVC-1:0] asg,
    output logic [VW-1:0]  cand_vc,
    output logic           cand_vld,
    output logic           avail
);
    logic [VW-1:0] ptr, ptr_n;
    int            rich_cnt;
    logic          rich_taken;

    // Search free channels starting at the rotation pointer.
    always_comb begin
        cand_vld = 1'b0;
        cand_vc  = '0;
        for (int k = 0; k < NVC; k++) begin
            if (!cand_vld && free[(int'(ptr) + k) % NVC]) begin
                cand_vld = 1'b1;
                cand_vc  = VW'((int'(ptr) + k) % NVC);
            end
        end
    end

    // Move the pointer one past any channel claimed this cycle.
    always_comb begin
        ptr_n = ptr;
        for (int k = 0; k < NVC; k++)
            if (asg[k]) ptr_n = VW'((k + 1) % NVC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_n;
    end

    // Count well-stocked free channels and see if one is being claimed.
    always_comb begin
        rich_cnt   = 0;
        rich_taken = 1'b0;
        for (int k = 0; k < NVC; k++) begin
            if (rich[k]) rich_cnt = rich_cnt + 1;
            if (rich[k] && asg[k]) rich_taken = 1'b1;
        end
    end

    // Registered availability flag with look-ahead on the current claim.
    always_ff @(posedge clk) begin
        if (!rst_n) avail <= AV_RST;
        else        avail <= (rich_cnt >= 2) || (rich_cnt == 1 && !rich_taken);
    end
endmodule

// File: rtl/ovc_status_tracker.sv
// Top: status of all output channels of all output ports of a router.
// Assumes one grant per output port per cycle and that a head grant with no
// prior channel names the port's current candidate.
module ovc_status_tracker #(
    parameter int NIN   = 4,
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    localparam int PW   = ovc_pkg::idx_width(NPORT),
    localparam int VW   = ovc_pkg::idx_width(NVC),
    localparam int NCH  = NPORT * NVC,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIN-1:0]    gnt_vld,
    input  logic [NIN*PW-1:0] gnt_port,
    input  logic [NIN*VW-1:0] gnt_vc,
    input  logic [NIN-1:0]    gnt_head,
    input  logic [NIN-1:0]    gnt_tail,
    input  logic [NCH-1:0]    cred_ret,
    output logic [NPORT*VW-1:0] cand_vc,
    output logic [NPORT-1:0]  cand_vld,
    output logic [NPORT-1:0]  port_avail,
    output logic [NCH-1:0]    vc_full,
    output logic [NCH-1:0]    vc_nfull
);
    logic [NCH-1:0]    use_stb, asg_stb, rel_stb;
    logic [NCH-1:0]    ch_owned, ch_free, ch_rich;
    logic [NCH*CW-1:0] ch_cred;

    ovc_grant_decode #(.NIN(NIN), .NPORT(NPORT), .NVC(NVC)) u_dec (
        .gnt_vld (gnt_vld),
        .gnt_port(gnt_port),
        .gnt_vc  (gnt_vc),
        .gnt_head(gnt_head),
        .gnt_tail(gnt_tail),
        .use_stb (use_stb),
        .asg_stb (asg_stb),
        .rel_stb (rel_stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ovc_channel_state #(.DEPTH(DEPTH)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .use_stb (use_stb[c]),
            .asg_stb (asg_stb[c]),
            .rel_stb (rel_stb[c]),
            .cred_ret(cred_ret[c]),
            .owned   (ch_owned[c]),
            .credits (ch_cred[c*CW +: CW]),
            .free    (ch_free[c]),
            .rich    (ch_rich[c]),
            .full    (vc_full[c]),
            .nfull   (vc_nfull[c])
        );
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ovc_port_pick #(.NVC(NVC), .DEPTH(DEPTH)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .free    (ch_free[p*NVC +: NVC]),
            .rich    (ch_rich[p*NVC +: NVC]),
            .asg     (asg_stb[p*NVC +: NVC]),
            .cand_vc (cand_vc[p*VW +: VW]),
            .cand_vld(cand_vld[p]),
            .avail   (port_avail[p])
        );
    end
endmodule

// File: rtl/ovc_status_checker.sv
// Assertions for the tracker, attached to every instance by bind.
module ovc_status_checker #(
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    localparam int VW   = ovc_pkg::idx_width(NVC),
    localparam int NCH  = NPORT * NVC,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    use_stb,
    input logic [NCH-1:0]    asg_stb,
    input logic [NCH-1:0]    rel_stb,
    input logic [NCH-1:0]    cred_ret,
    input logic [NCH-1:0]    ch_owned,
    input logic [NCH-1:0]    ch_free,
    input logic [NCH*CW-1:0] ch_cred,
    input logic [NPORT*VW-1:0] cand_vc,
    input logic [NPORT-1:0]  cand_vld,
    input logic [NPORT-1:0]  port_avail
);
    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R4: a head grant leaves the channel owned on the next cycle.
        a_r4_assign_sets: assert property (@(posedge clk) disable iff (!rst_n)
            asg_stb[c] && !rel_stb[c] |=> ch_owned[c]);
        // R4: a tail grant leaves the channel unowned on the next cycle.
        a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
            rel_stb[c] |=> !ch_owned[c]);
        // R5: a grant without a return costs exactly one credit.
        a_r5_use_decrements: assert property (@(posedge clk) disable iff (!rst_n)
            use_stb[c] && !cred_ret[c] |=>
            ch_cred[c*CW +: CW] == $past(ch_cred[c*CW +: CW]) - CW'(1));
        // R6: the credit count stays within the buffer depth.
        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            ch_cred[c*CW +: CW] <= CW'(DEPTH));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        // R2: the offered candidate is a free channel of that port.
        a_r2_cand_free: assert property (@(posedge clk) disable iff (!rst_n)
            cand_vld[p] |-> ch_free[p*NVC + int'(cand_vc[p*VW +: VW])]);
        // R7: a port flagged available has at least one free channel.
        a_r7_avail_has_free: assert property (@(posedge clk) disable iff (!rst_n)
            port_avail[p] |-> |ch_free[p*NVC +: NVC]);
    end
endmodule

bind ovc_status_tracker ovc_status_checker #(
    .NPORT(NPORT), .NVC(NVC), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .use_stb   (use_stb),
    .asg_stb   (asg_stb),
    .rel_stb   (rel_stb),
    .cred_ret  (cred_ret),
    .ch_owned  (ch_owned),
    .ch_free   (ch_free),
    .ch_cred   (ch_cred),
    .cand_vc   (cand_vc),
    .cand_vld  (cand_vld),
    .port_avail(port_avail)
);

// File: tb/ovc_status_tracker_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module ovc_status_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NIN = 4, NPORT = 4, NVC = 2, DEPTH = 4;
    localparam int PW = 2, VW = 1, NCH = NPORT * NVC;

    logic clk = 1'b0;
    logic rst_n;
    logic [NIN-1:0]    gnt_vld, gnt_head, gnt_tail;
    logic [NIN*PW-1:0] gnt_port;
    logic [NIN*VW-1:0] gnt_vc;
    logic [NCH-1:0]    cred_ret;
    logic [NPORT*VW-1:0] cand_vc;
    logic [NPORT-1:0]  cand_vld, port_avail;
    logic [NCH-1:0]    vc_full, vc_nfull;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ovc_status_tracker #(.NIN(NIN), .NPORT(NPORT), .NVC(NVC), .DEPTH(DEPTH)) u_ovc_status_tracker (
        .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_port(gnt_port),
        .gnt_vc(gnt_vc), .gnt_head(gnt_head), .gnt_tail(gnt_tail),
        .cred_ret(cred_ret), .cand_vc(cand_vc), .cand_vld(cand_vld),
        .port_avail(port_avail), .vc_full(vc_full), .vc_nfull(vc_nfull)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        gnt_vld = '0; gnt_head = '0; gnt_tail = '0;
        gnt_port = '0; gnt_vc = '0; cred_ret = '0;
    endtask

    task automatic grant(input int i, input int p, input int v, input bit h, input bit t);
        gnt_vld[i] = 1'b1;
        gnt_port[i*PW +: PW] = PW'(p);
        gnt_vc[i*VW +: VW]   = VW'(v);
        gnt_head[i] = h;
        gnt_tail[i] = t;
    endtask

    // Clock the applied inputs in, then sample on the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    function automatic int cand(input int p);
        return int'(cand_vc[p*VW +: VW]);
    endfunction

    task automatic t_reset();
        chk("R1 cand_vld", int'(cand_vld), 4'hF);
        chk("R1 port_avail", int'(port_avail), 4'hF);
        chk("R1 cand_vc", int'(cand_vc), 0);
        chk("R1 vc_full", int'(vc_full), 0);
        chk("R1 vc_nfull", int'(vc_nfull), 0);
    endtask

    // Port 1 channel 0 (flat 2): claim, drain credits, return credits.
    task automatic t_credit();
        grant(0, 1, 0, 1'b1, 1'b0); tick();
        chk("R4 cand moves off owned ch", cand(1), 1);
        chk("R7 avail with two rich", int'(port_avail[1]), 1);
        grant(0, 1, 0, 1'b0, 1'b0); tick();
        grant(0, 1, 0, 1'b0, 1'b0); tick();
        chk("R5 nfull at one credit", int'(vc_nfull[2]), 1);
        chk("R5 not full at one credit", int'(vc_full[2]), 0);
        grant(0, 1, 0, 1'b0, 1'b0); tick();
        chk("R5 full at zero credits", int'(vc_full[2]), 1);
        cred_ret[2] = 1'b1; tick();
        chk("R6 return adds credit", int'(vc_nfull[2]), 1);
        grant(0, 1, 0, 1'b0, 1'b0); cred_ret[2] = 1'b1; tick();
        chk("R6 grant and return cancel", int'(vc_nfull[2]), 1);
        chk("R6 grant and return not full", int'(vc_full[2]), 0);
    endtask

    // Tail frees channel early; it returns as candidate with one credit.
    task automatic t_reuse();
        grant(1, 1, 0, 1'b0, 1'b1); tick();
        chk("R5 tail uses last credit", int'(vc_full[2]), 1);
        chk("R2 empty released ch not offered", cand(1), 1);
        cred_ret[2] = 1'b1; tick();
        chk("R7 avail one rich not taken", int'(port_avail[1]), 1);
        grant(1, 1, 1, 1'b1, 1'b0); tick();
        chk("R8 released ch offered again", cand(1), 0);
        chk("R8 cand valid", int'(cand_vld[1]), 1);
        chk("R7 last rich ch taken drops avail", int'(port_avail[1]), 0);
    endtask

    // Port 2: single-flit packets rotate the candidate.
    task automatic t_rotate();
        grant(2, 2, 0, 1'b1, 1'b1); tick();
        chk("R3 rotate past ch0", cand(2), 1);
        chk("R4 head+tail leaves ch free", int'(cand_vld[2]), 1);
        grant(2, 2, 1, 1'b1, 1'b1); tick();
        chk("R3 wrap to ch0", cand(2), 0);
        chk("R5 one credit used each", int'(vc_nfull[5:4]), 0);
    endtask

    // Port 3: availability flag timing when every channel is owned.
    task automatic t_avail();
        grant(0, 3, 0, 1'b1, 1'b0); tick();
        chk("R7 avail stays with second rich", int'(port_avail[3]), 1);
        grant(0, 3, 1, 1'b1, 1'b0); tick();
        chk("R7 avail drops on last claim", int'(port_avail[3]), 0);
        chk("R2 no free ch", int'(cand_vld[3]), 0);
        grant(0, 3, 1, 1'b0, 1'b1); tick();
        chk("R2 released ch offered", cand(3), 1);
        chk("R7 flag uses state before edge", int'(port_avail[3]), 0);
        tick();
        chk("R7 flag recovers one edge later", int'(port_avail[3]), 1);
    endtask

    // Two input ports acting on different output ports in one cycle.
    task automatic t_parallel();
        grant(2, 0, 0, 1'b1, 1'b0);
        grant(3, 3, 0, 1'b0, 1'b1);
        tick();
        chk("R9 port0 claim applied", cand(0), 1);
        chk("R9 port3 release applied", cand(3), 0);
        chk("R9 port3 both free", int'(cand_vld[3]), 1);
        chk("R7 port3 avail", int'(port_avail[3]), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_credit();
        t_reuse();
        t_rotate();
        t_avail();
        t_parallel();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule